// File: doc/BRIEF.md
# Dual-Clock Line Delay Memory

This block is a line-length delay store with two ports that never share a clock. The write side copies one word per enabled write-clock edge into a dual-port array at an address that steps on its own. The read side fetches one word per enabled read-clock edge at an address that also steps on its own. The block has no occupancy tracking and no full or empty flags. The distance between the two address counters is the delay, and that distance is set only by when each side was last rewound to word zero.

A typical use is one scan line of image data. The producer rewinds the write side at the start of a line and streams pixels in. Some time later the consumer rewinds the read side and streams the same pixels out in the same order, so the output is the input delayed by the gap between the two rewinds. The read word is registered, and a registered drive-enable turns the data bus into a three-state output. The array is written so that it maps onto a simple dual-port block RAM with a registered read port.

Top module: `line_delay_mem`

## Requirements
- R1: The array holds DEPTH words of WIDTH bits (default 1152 by 8). A word read from an address equals the last word written to that address.
- R2: On a rising `wr_clk` edge with `wr_rewind_n`=1 and `wr_en_n`=0, `wr_data` is stored at the write address, and the write address then advances by one.
- R3: On a rising `wr_clk` edge with `wr_rewind_n`=1 and `wr_en_n`=1, nothing is stored and the write address holds.
- R4: On a rising `wr_clk` edge with `wr_rewind_n`=0, the write address becomes 0 and nothing is stored, even when `wr_en_n`=0 (rewind wins). The next enabled write goes to word 0.
- R5: On a rising `rd_clk` edge with `rd_rewind_n`=1 and `rd_en_n`=0, the word at the read address appears on `rd_data` after that edge, and the read address advances by one. A following edge with `rd_en_n`=1 holds the address, so reading resumes at the next word.
- R6: On a rising `rd_clk` edge with `rd_rewind_n`=0, the read address becomes 0 and no read takes place, even when `rd_en_n`=0 (rewind wins).
- R7: Each address counter wraps from DEPTH-1 to 0 when it is neither rewound nor disabled, so writing past the end overwrites words from word 0 onward.
- R8: `rd_oe` is 1 in the read-clock cycle that follows an edge that performed a read, and 0 otherwise. While `rd_oe` is 1, `rd_bus` equals `rd_data`. While `rd_oe` is 0, `rd_bus` is high-impedance.
- R9: The two ports run from unrelated clocks. If the read side is rewound while writing continues, and it stays behind the write address, it returns the words written since the write rewind in their write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rewind_n | input | 1 | Active-low synchronous rewind of the write address to 0 |
| wr_en_n | input | 1 | Active-low write enable |
| wr_data | input | WIDTH | Word to store |
| rd_clk | input | 1 | Read-side clock, unrelated to `wr_clk` |
| rd_rewind_n | input | 1 | Active-low synchronous rewind of the read address to 0 |
| rd_en_n | input | 1 | Active-low read enable |
| rd_data | output | WIDTH | Registered read word |
| rd_oe | output | 1 | Registered drive-enable for `rd_bus` |
| rd_bus | output | WIDTH | Three-state copy of `rd_data` |

## Verification
The bench builds the block with WIDTH=8 and DEPTH=40. At that depth a single pass past the end of the array takes only a few dozen cycles, so the wrap from the last word back to word 0 and the overwrite that follows it are exercised directly. The default depth of 1152 would make that pass much longer. With a short array, the bench can also run a write stream and a lagging read stream at the same time on an 8 ns clock and an 11 ns clock without the reader catching up with the writer.

// File: rtl/ldm_pkg.sv
package ldm_pkg;
  // Address width for a given depth, never below one bit.
  function automatic int unsigned ldm_addr_bits(input int unsigned depth);
    int unsigned w;
    w = $clog2(depth);
    return (w < 1) ? 1 : w;
  endfunction

  // Action taken by a port on one of its clock edges.
  typedef enum logic [1:0] {
    PORT_IDLE   = 2'd0,
    PORT_STEP   = 2'd1,
    PORT_REWIND = 2'd2
  } port_act_e;
endpackage

// File: rtl/ldm_addr_ctr.sv
module ldm_addr_ctr
  import ldm_pkg::*;
#(
  parameter int unsigned DEPTH = 1152,
  parameter int unsigned AW    = ldm_addr_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rewind_n,
  input  logic          en_n,
  output logic [AW-1:0] addr,
  output logic          step
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  port_act_e     act;
  logic [AW-1:0] addr_q = '0;

  always_comb begin
    if (!rewind_n)   act = PORT_REWIND;
    else if (!en_n)  act = PORT_STEP;
    else             act = PORT_IDLE;
  end

  always_ff @(posedge clk) begin
    unique case (act)
      PORT_REWIND: addr_q <= '0;
      PORT_STEP:   addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
      default:     addr_q <= addr_q;
    endcase
  end

  assign addr = addr_q;
  assign step = (act == PORT_STEP);
endmodule

// File: rtl/ldm_dp_ram.sv
module ldm_dp_ram #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 1152,
  parameter int unsigned AW    = 11
) (
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_q
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] q_r = '0;

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) q_r <= mem[rd_addr];
  end

  assign rd_q = q_r;
endmodule

// File: rtl/line_delay_mem.sv
module line_delay_mem
  import ldm_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 1152
) (
  input  logic             wr_clk,
  input  logic             wr_rewind_n,
  input  logic             wr_en_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_clk,
  input  logic             rd_rewind_n,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe,
  output logic [WIDTH-1:0] rd_bus
);
  localparam int unsigned AW = ldm_addr_bits(DEPTH);

  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          wr_step;
  logic          rd_step;
  logic          oe_q = 1'b0;

  ldm_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_wr_ctr (
    .clk      (wr_clk),
    .rewind_n (wr_rewind_n),
    .en_n     (wr_en_n),
    .addr     (wr_addr),
    .step     (wr_step)
  );

  ldm_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_rd_ctr (
    .clk      (rd_clk),
    .rewind_n (rd_rewind_n),
    .en_n     (rd_en_n),
    .addr     (rd_addr),
    .step     (rd_step)
  );

  ldm_dp_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .wr_clk  (wr_clk),
    .wr_en   (wr_step),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_clk  (rd_clk),
    .rd_en   (rd_step),
    .rd_addr (rd_addr),
    .rd_q    (rd_data)
  );

  // Drive-enable follows the read action of the previous edge.
  always_ff @(posedge rd_clk) begin
    oe_q <= rd_step;
  end

  assign rd_oe  = oe_q;
  assign rd_bus = oe_q ? rd_data : {WIDTH{1'bz}};
endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 1152,
  parameter int unsigned AW    = 11
) (
  input logic             wr_clk,
  input logic             wr_rewind_n,
  input logic             wr_en_n,
  input logic             rd_clk,
  input logic             rd_rewind_n,
  input logic             rd_en_n,
  input logic [AW-1:0]    wr_addr,
  input logic [AW-1:0]    rd_addr,
  input logic [WIDTH-1:0] rd_data,
  input logic             rd_oe
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic wr_armed = 1'b0;
  logic rd_armed = 1'b0;

  always_ff @(posedge wr_clk) if (!wr_rewind_n) wr_armed <= 1'b1;
  always_ff @(posedge rd_clk) if (!rd_rewind_n) rd_armed <= 1'b1;

  AST_WR_REWIND_ZERO: assert property (@(posedge wr_clk) disable iff (!wr_armed)
    !wr_rewind_n |=> wr_addr == '0); // R4

  AST_WR_DISABLED_HOLD: assert property (@(posedge wr_clk) disable iff (!wr_armed)
    (wr_rewind_n && wr_en_n) |=> $stable(wr_addr)); // R3

  AST_WR_STEP_WRAP: assert property (@(posedge wr_clk) disable iff (!wr_armed)
    (wr_rewind_n && !wr_en_n && wr_addr == LAST) |=> wr_addr == '0); // R7

  AST_RD_REWIND_NO_READ: assert property (@(posedge rd_clk) disable iff (!rd_armed)
    !rd_rewind_n |=> (rd_addr == '0 && !rd_oe)); // R6

  AST_RD_OE_AFTER_READ: assert property (@(posedge rd_clk) disable iff (!rd_armed)
    (rd_rewind_n && !rd_en_n) |=> rd_oe); // R8

  AST_RD_DISABLED_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_armed)
    (rd_rewind_n && rd_en_n) |=> ($stable(rd_addr) && $stable(rd_data) && !rd_oe)); // R5
endmodule

bind line_delay_mem ldm_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_chk (
  .wr_clk      (wr_clk),
  .wr_rewind_n (wr_rewind_n),
  .wr_en_n     (wr_en_n),
  .rd_clk      (rd_clk),
  .rd_rewind_n (rd_rewind_n),
  .rd_en_n     (rd_en_n),
  .wr_addr     (wr_addr),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .rd_oe       (rd_oe)
);

// File: tb/line_delay_mem_bench.sv
module line_delay_mem_bench;
  localparam int W = 8;
  localparam int D = 40;

  logic         wr_clk = 1'b0;
  logic         rd_clk = 1'b0;
  logic         wr_rewind_n = 1'b1;
  logic         wr_en_n = 1'b1;
  logic [W-1:0] wr_data = '0;
  logic         rd_rewind_n = 1'b1;
  logic         rd_en_n = 1'b1;
  logic [W-1:0] rd_data;
  logic         rd_oe;
  wire  [W-1:0] rd_bus;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;
  logic [W-1:0] exp_q [$];

  always #4   wr_clk = ~wr_clk;   // 125 MHz
  always #5.5 rd_clk = ~rd_clk;   // unrelated read clock

  line_delay_mem #(.WIDTH(W), .DEPTH(D)) u_line_delay_mem (
    .wr_clk(wr_clk), .wr_rewind_n(wr_rewind_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rewind_n(rd_rewind_n), .rd_en_n(rd_en_n),
    .rd_data(rd_data), .rd_oe(rd_oe), .rd_bus(rd_bus)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected word for every read the design reports.
  always @(negedge rd_clk) begin
    if (mon_on && rd_oe) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected read", int'(rd_data), -1);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R1/R5/R9 read order", int'(rd_data), int'(e));
        check(rd_bus == rd_data, "R8 bus drives data", int'(rd_bus), int'(rd_data));
      end
    end
  end

  task automatic wr_rewind(input bit with_en);
    @(negedge wr_clk);
    wr_rewind_n = 1'b0; wr_en_n = !with_en; wr_data = 8'hEE;
    @(negedge wr_clk);
    wr_rewind_n = 1'b1; wr_en_n = 1'b1;
  endtask

  task automatic wr_word(input logic [W-1:0] v, input bit push);
    @(negedge wr_clk);
    wr_en_n = 1'b0; wr_data = v;
    if (push) exp_q.push_back(v);
  endtask

  task automatic wr_idle();
    @(negedge wr_clk);
    wr_en_n = 1'b1; wr_data = 8'h33;
  endtask

  // Rewind with the enable held low: R6 says no read takes place.
  task automatic rd_rewind();
    @(negedge rd_clk);
    rd_rewind_n = 1'b0; rd_en_n = 1'b0;
    @(negedge rd_clk);
    check(rd_oe == 1'b0, "R6 rewind performs no read", int'(rd_oe), 0);
    rd_rewind_n = 1'b1; rd_en_n = 1'b1;
  endtask

  task automatic rd_read(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rd_clk);
      rd_en_n = 1'b0;
    end
  endtask

  task automatic rd_idle();
    @(negedge rd_clk);
    rd_en_n = 1'b1;
    @(negedge rd_clk);
    check(rd_oe == 1'b0, "R8 no drive when disabled", int'(rd_oe), 0);
  endtask

  initial begin
    #(200000 * 8);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge rd_clk);
    check(rd_oe == 1'b0, "R8 reset state undriven", int'(rd_oe), 0);
    mon_on = 1'b1;

    // R2 R3 R4 R5: writes with disable gaps, reads with disable gaps.
    wr_rewind(1'b0);
    for (int i = 0; i < 6; i++) begin
      wr_word(8'h10 + 8'(i), 1'b1);
      wr_idle();
    end
    wr_idle();
    rd_rewind();
    rd_read(3); rd_idle(); rd_idle();
    rd_read(3); rd_idle();
    check(exp_q.size() == 0, "R3/R5 all gapped words read", exp_q.size(), 0);

    // R4 R6: rewind wins over an active enable on both ports.
    wr_rewind(1'b0);
    wr_word(8'hA0, 1'b0); wr_word(8'hA1, 1'b0); wr_word(8'hA2, 1'b0);
    wr_rewind(1'b1);
    wr_word(8'hB0, 1'b1);
    wr_idle();
    exp_q.push_back(8'hA1); exp_q.push_back(8'hA2);
    rd_rewind();
    rd_read(3); rd_idle();
    check(exp_q.size() == 0, "R4 rewind wins on write", exp_q.size(), 0);

    // R7: write past the end, then read one full pass plus two.
    wr_rewind(1'b0);
    for (int i = 0; i < D + 5; i++) wr_word(8'(i) ^ 8'h5A, 1'b0);
    wr_idle();
    for (int i = 0; i < D; i++) exp_q.push_back(8'((i < 5) ? D + i : i) ^ 8'h5A);
    exp_q.push_back(8'(D) ^ 8'h5A);
    exp_q.push_back(8'(D + 1) ^ 8'h5A);
    rd_rewind();
    rd_read(D + 2); rd_idle();
    check(exp_q.size() == 0, "R7 wrap and overwrite", exp_q.size(), 0);

    // R9: read rewound while writing continues, on unrelated clocks.
    fork
      begin
        wr_rewind(1'b0);
        for (int i = 0; i < 30; i++) wr_word(8'hC0 ^ 8'(i * 3), 1'b1);
        wr_idle();
      end
      begin
        repeat (12) @(negedge wr_clk);
        rd_rewind();
        rd_read(30); rd_idle();
      end
    join
    check(exp_q.size() == 0, "R9 delayed stream complete", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule